// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the device-side burst engine of a synchronous DRAM model. A mode-load command programs how many beats a burst has, whether the column order wraps sequentially or by XOR interleave, and how many clocks pass between a read command and its first data. Each read or write command latches a start column. The block then presents one column per clock on `col_o` until the programmed length is used up. A full-page setting keeps the burst going until something stops it.

For writes, a per-beat enable drops when the byte mask is high on that beat's own clock edge. For reads, a data-valid strobe follows the column stream after the programmed latency. That strobe is suppressed by a mask seen two edges before the data is sampled. A burst ends early on a terminate or precharge command. A new read or write stops it too, and starts over at its own column. The memory array, refresh and analog timing sit outside this block. The reset input is asynchronous and is released inside the block through a two-stage synchronizer.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset no burst, write enable, read strobe or error is active, and the mode is one beat, sequential, latency 2.
- R2: A mode load (`cmd_i`=001) with `addr_i[2:0]` of 000/001/010/011/111 selects 1/2/4/8 beats or full page. `addr_i[3]`=1 selects interleaved order. `addr_i[6:4]` of 010/011 selects latency 2/3. A legal load leaves `mode_err_o` low.
- R3: A mode load is rejected in several cases: another length code, another latency code, full page with interleave, any of `addr_i[11:7]` nonzero, or `ba_i` nonzero. The rejected load pulses `mode_err_o` for exactly the next cycle and leaves the previous mode in force.
- R4: A read (`cmd_i`=010) or write (011) sampled at edge k presents beat i on `col_o` with `col_valid_o` high in the cycle after edge k+i, for exactly the burst length.
- R5: In sequential order the low log2(length) column bits count up from the start column and wrap, while the upper bits stay at the start column's.
- R6: In interleaved order the low log2(length) bits equal the start column XOR the beat index, and the upper bits stay fixed.
- R7: In full-page mode the column counts up modulo the column count with no end.
- R8: A read beat i is flagged by `rd_valid_o` in the cycle after edge k+CL-1+i, so the data is sampled at edge k+CL+i.
- R9: `wr_en_o` is high on a write beat unless `dqm_i` was high at the edge that issued that beat.
- R10: `dqm_i` high at edge m suppresses the `rd_valid_o` sampled at edge m+2.
- R11: A terminate (100) or precharge (101) at edge t stops the beats from the cycle after t, and read beats issued before t are still delivered.
- R12: A read or write during a burst restarts at its own column with beat 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command: 000 none, 001 mode load, 010 read, 011 write, 100 terminate, 101 precharge |
| addr_i | input | ADDR_W | Start column on low bits, or mode fields on a load |
| ba_i | input | BA_W | Bank bits, must be zero on a load |
| dqm_i | input | 1 | Byte mask |
| col_o | output | log2(COLS) | Column of the current beat |
| col_valid_o | output | 1 | A beat is presented |
| wr_en_o | output | 1 | Unmasked write beat |
| rd_valid_o | output | 1 | Read data valid, after latency and mask |
| mode_err_o | output | 1 | Rejected mode load, one-cycle pulse |

## Verification
The bench sweeps every start column of a small 16-column array across all lengths, both orders, both latencies and both directions. Every beat's column is compared against arithmetic wrap and XOR formulas. A design that carried into the upper column bits, or that used addition in interleaved order, fails there at the start columns near a wrap. Mask patterns are staggered against the beat stream, so that applying the read mask with the write latency, or the reverse, drops the wrong beat. The targeted cases are a full-page wrap past the last column, cut-offs by terminate, precharge and a new command, and reserved loads followed by a burst. That burst would show any partial update of the mode.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_MRS  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_TERM = 3'd4,
    CMD_PRE  = 3'd5
  } cmd_e;

  typedef struct packed {
    logic       full;  // full-page burst
    logic [1:0] lg;    // log2 of burst length
    logic       ilv;   // interleaved order
    logic       cl3;   // latency 3 when set, else 2
  } mode_t;

  localparam int LEN_LSB  = 0;
  localparam int TYPE_BIT = 3;
  localparam int LAT_LSB  = 4;
  localparam int RSVD_LSB = 7;

  localparam int MIN_LAT  = 2;
  localparam int MAX_LAT  = 3;

  localparam mode_t MODE_RST = '{full: 1'b0, lg: 2'd0, ilv: 1'b0, cl3: 1'b0};

endpackage

// File: rtl/bseq_mode_reg.sv
module bseq_mode_reg
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BA_W-1:0]   ba_i,
  output mode_t             mode_o,
  output logic              err_o
);

  logic [2:0] len_f;
  logic [2:0] lat_f;
  mode_t      dec;
  mode_t      mode_n;
  logic       bad;
  logic       err_n;

  always_comb begin
    len_f   = addr_i[LEN_LSB +: 3];
    lat_f   = addr_i[LAT_LSB +: 3];
    dec     = MODE_RST;
    dec.ilv = addr_i[TYPE_BIT];
    bad     = 1'b0;
    case (len_f)
      3'b000:  dec.lg = 2'd0;
      3'b001:  dec.lg = 2'd1;
      3'b010:  dec.lg = 2'd2;
      3'b011:  dec.lg = 2'd3;
      3'b111:  dec.full = 1'b1;
      default: bad = 1'b1;
    endcase
    if (dec.full && dec.ilv) bad = 1'b1;
    case (lat_f)
      3'b010:  dec.cl3 = 1'b0;
      3'b011:  dec.cl3 = 1'b1;
      default: bad = 1'b1;
    endcase
    if ((|addr_i[ADDR_W-1:RSVD_LSB]) || (|ba_i)) bad = 1'b1;
    mode_n = (load_i && !bad) ? dec : mode_o;
    err_n  = load_i && bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= MODE_RST;
      err_o  <= 1'b0;
    end else begin
      mode_o <= mode_n;
      err_o  <= err_n;
    end
  end

  // R3
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (mode_o == $past(mode_o)));

  // R3
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(load_i));

endmodule

// File: rtl/bseq_col_gen.sv
module bseq_col_gen
  import bseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] cnt_i,
  input  mode_t            mode_i,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);

  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] step;

  always_comb begin
    mask   = mode_i.full ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << mode_i.lg);
    step   = mode_i.ilv ? (start_i ^ cnt_i) : (start_i + cnt_i);
    col_o  = (start_i & ~mask) | (step & mask);
    last_o = !mode_i.full && (cnt_i == mask);
  end

endmodule

// File: rtl/bseq_rd_pipe.sv
module bseq_rd_pipe
  import bseq_pkg::*;
#(
  parameter int NSTG  = MAX_LAT - 1,
  localparam int SEL_W = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_i,
  input  logic             mask_q_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             valid_o
);

  logic [NSTG-1:0] stg_q;
  logic            mask2_q;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    logic d;
    if (g == 0) begin : g_head
      assign d = beat_i;
    end else begin : g_tail
      assign d = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= 1'b0;
      else        stg_q[g] <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask2_q <= 1'b0;
    else        mask2_q <= mask_q_i;
  end

  assign valid_o = stg_q[sel_i] & ~mask2_q;

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import bseq_pkg::*;
#(
  parameter int COLS   = 1024,
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic              dqm_i,
  output logic [COL_W-1:0]  col_o,
  output logic              col_valid_o,
  output logic              wr_en_o,
  output logic              rd_valid_o,
  output logic              mode_err_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // command decode
  logic is_rd, is_wr, is_mrs, start_rw, stop;
  always_comb begin
    is_rd    = (cmd_i == CMD_RD);
    is_wr    = (cmd_i == CMD_WR);
    is_mrs   = (cmd_i == CMD_MRS);
    start_rw = is_rd | is_wr;
    stop     = (cmd_i == CMD_TERM) | (cmd_i == CMD_PRE);
  end

  mode_t mode_q;

  bseq_mode_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_mode (
    .clk    (clk),
    .rst_n  (srst_n),
    .load_i (is_mrs),
    .addr_i (addr_i),
    .ba_i   (ba_i),
    .mode_o (mode_q),
    .err_o  (mode_err_o)
  );

  // burst state
  logic             act_q,   act_n;
  logic             wr_q,    wr_n;
  logic [COL_W-1:0] start_q, start_n;
  logic [COL_W-1:0] cnt_q,   cnt_n;
  logic             dqm_q;
  logic             last;
  logic             st_en;

  bseq_col_gen #(.COL_W(COL_W)) u_col (
    .start_i (start_q),
    .cnt_i   (cnt_q),
    .mode_i  (mode_q),
    .col_o   (col_o),
    .last_o  (last)
  );

  always_comb begin
    st_en   = start_rw | stop | act_q;
    act_n   = act_q;
    wr_n    = wr_q;
    start_n = start_q;
    cnt_n   = cnt_q;
    if (start_rw) begin
      act_n   = 1'b1;
      wr_n    = is_wr;
      start_n = addr_i[COL_W-1:0];
      cnt_n   = '0;
    end else if (stop) begin
      act_n = 1'b0;
    end else if (act_q) begin
      if (last) act_n = 1'b0;
      else      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (st_en) begin
      act_q   <= act_n;
      wr_q    <= wr_n;
      start_q <= start_n;
      cnt_q   <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) dqm_q <= 1'b0;
    else         dqm_q <= dqm_i;
  end

  assign col_valid_o = act_q;
  assign wr_en_o     = act_q & wr_q & ~dqm_q;

  bseq_rd_pipe #(.NSTG(MAX_LAT - 1)) u_rd (
    .clk      (clk),
    .rst_n    (srst_n),
    .beat_i   (act_q & ~wr_q),
    .mask_q_i (dqm_q),
    .sel_i    (mode_q.cl3),
    .valid_o  (rd_valid_o)
  );

  // R4
  wr_beat_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en_o |-> col_valid_o);

  // R4
  burst_len_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $past(col_valid_o && last && !start_rw) |-> !col_valid_o);

  // R11
  stop_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $past(stop && !start_rw) |-> !col_valid_o);

  // R12
  restart_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $past(start_rw) |-> (col_valid_o && (col_o == $past(addr_i[COL_W-1:0]))));

  // R8
  rd_lat2_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_valid_o && !mode_q.cl3) |-> $past(col_valid_o && !wr_q));

  // R8
  rd_lat3_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_valid_o && mode_q.cl3) |-> $past(col_valid_o && !wr_q, 2));

endmodule

// File: tb/tb_sdram_burst_seq.sv
module tb_sdram_burst_seq;

  localparam int CLK_PERIOD = 10;
  localparam int COLS = 16;
  localparam int CW   = 4;

  localparam logic [2:0] C_NOP = 3'd0, C_MRS = 3'd1, C_RD = 3'd2,
                         C_WR = 3'd3, C_TERM = 3'd4, C_PRE = 3'd5;

  logic          clk, rst_n;
  logic [2:0]    cmd;
  logic [11:0]   addr;
  logic [1:0]    ba;
  logic          dqm;
  logic [CW-1:0] col;
  logic          col_valid, wr_en, rd_valid, mode_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  sdram_burst_seq #(.COLS(COLS), .ADDR_W(12), .BA_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .addr_i(addr), .ba_i(ba),
    .dqm_i(dqm), .col_o(col), .col_valid_o(col_valid), .wr_en_o(wr_en),
    .rd_valid_o(rd_valid), .mode_err_o(mode_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(int start, int j, int lg, int ilv, int full);
    int mask, low;
    if (full != 0) return (start + j) % COLS;
    mask = (1 << lg) - 1;
    low  = (ilv != 0) ? ((start ^ j) & mask) : ((start + j) & mask);
    return (start & ~mask) | low;
  endfunction

  task automatic mrs(int bl_code, int bt, int cl_code, int upper, int bav,
                     int exp_err, string req);
    @(negedge clk);
    cmd  = C_MRS;
    addr = 12'((upper << 7) | (cl_code << 4) | (bt << 3) | bl_code);
    ba   = 2'(bav);
    @(negedge clk);
    cmd = C_NOP; addr = '0; ba = '0;
    check(req, int'(mode_err), exp_err);
  endtask

  task automatic burst(int wr, int start, int lg, int ilv, int cl,
                       logic [15:0] pat, string tag);
    int bl, b, exp_rd;
    bl = 1 << lg;
    @(negedge clk);
    cmd = (wr != 0) ? C_WR : C_RD;
    addr = 12'(start);
    dqm = pat[0];
    for (int j = 0; j < bl + cl + 1; j++) begin
      @(negedge clk);
      cmd = C_NOP; addr = '0;
      check({tag, " R4 col_valid"}, int'(col_valid), int'(j < bl));
      if (j < bl)
        check({tag, (ilv != 0) ? " R6 interleaved column" : " R5 sequential column"},
              int'(col), exp_col(start, j, lg, ilv, 0));
      check({tag, " R9 write enable"}, int'(wr_en),
            int'((wr != 0) && (j < bl) && !pat[j]));
      b = j - cl + 1;
      exp_rd = int'((wr == 0) && (b >= 0) && (b < bl) && !((j >= 1) && pat[j-1]));
      check({tag, (pat != 0) ? " R10 read mask" : " R8 read latency"},
            int'(rd_valid), exp_rd);
      dqm = pat[j+1];
    end
    dqm = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] pat;
    rst_n = 1'b0; cmd = C_NOP; addr = '0; ba = '0; dqm = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset col_valid", int'(col_valid), 0);
    check("R1 reset wr_en", int'(wr_en), 0);
    check("R1 reset rd_valid", int'(rd_valid), 0);
    check("R1 reset mode_err", int'(mode_err), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 default mode: one beat, sequential, latency 2
    cmd = C_RD; addr = 12'd3;
    @(negedge clk); cmd = C_NOP; addr = '0;
    check("R1 default beat column", int'(col), 3);
    check("R1 default beat valid", int'(col_valid), 1);
    check("R1 default no read yet", int'(rd_valid), 0);
    @(negedge clk);
    check("R1 default one beat", int'(col_valid), 0);
    check("R1 default latency 2", int'(rd_valid), 1);
    @(negedge clk);
    check("R1 default single data", int'(rd_valid), 0);

    // sweep over lengths, orders, latencies, start columns and directions
    for (int cl = 2; cl <= 3; cl++)
      for (int bt = 0; bt <= 1; bt++)
        for (int lg = 0; lg <= 3; lg++) begin
          mrs(lg, bt, cl, 0, 0, 0, "R2 legal mode load");
          for (int st = 0; st < COLS; st++)
            for (int wr = 0; wr <= 1; wr++) begin
              pat = ((st % 3) == 0) ? 16'h0000 : (16'h05A5 >> (st % 4));
              burst(wr, st, lg, bt, cl, pat, "sweep");
            end
        end

    // R7 full page wraps and runs until terminated
    mrs(7, 0, 2, 0, 0, 0, "R2 full page load");
    @(negedge clk); cmd = C_RD; addr = 12'd13;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk); cmd = C_NOP; addr = '0;
      check("R7 full page valid", int'(col_valid), 1);
      check("R7 full page column", int'(col), (13 + j) % COLS);
      if (j == 19) cmd = C_TERM;
    end
    @(negedge clk); cmd = C_NOP;
    check("R11 terminate stops full page", int'(col_valid), 0);
    check("R11 issued read beat delivered", int'(rd_valid), 1);
    @(negedge clk);
    check("R11 no data after terminate", int'(rd_valid), 0);
    repeat (3) @(negedge clk);

    // R3 reserved loads keep interleaved 4 beats, latency 3
    mrs(2, 1, 3, 0, 0, 0, "R2 load before reserved");
    mrs(5, 0, 2, 0, 0, 1, "R3 reserved length");
    mrs(2, 0, 1, 0, 0, 1, "R3 reserved latency");
    mrs(7, 1, 2, 0, 0, 1, "R3 interleaved full page");
    mrs(1, 0, 2, 2, 0, 1, "R3 upper address bits");
    mrs(1, 0, 2, 0, 1, 1, "R3 bank bits");
    @(negedge clk);
    check("R3 error pulse one cycle", int'(mode_err), 0);
    burst(0, 6, 2, 1, 3, 16'h0000, "R3 mode kept");

    // R11 write cut by terminate
    mrs(3, 0, 2, 0, 0, 0, "R2 eight beats");
    @(negedge clk); cmd = C_WR; addr = 12'd2;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); cmd = C_NOP; addr = '0;
      check("R11 write beat before stop", int'(col), 2 + j);
      check("R11 write enable before stop", int'(wr_en), 1);
      if (j == 2) cmd = C_TERM;
    end
    @(negedge clk); cmd = C_NOP;
    check("R11 write stopped", int'(col_valid), 0);
    check("R11 no write after stop", int'(wr_en), 0);
    repeat (3) @(negedge clk);

    // R11 read cut by precharge, latency 3
    mrs(3, 0, 3, 0, 0, 0, "R2 eight beats latency 3");
    @(negedge clk); cmd = C_RD; addr = 12'd4;
    @(negedge clk); cmd = C_NOP; addr = '0;
    check("R11 read beat 0", int'(col), 4);
    @(negedge clk); cmd = C_PRE;
    check("R11 read beat 1", int'(col), 5);
    @(negedge clk); cmd = C_NOP;
    check("R11 precharge stops beats", int'(col_valid), 0);
    check("R11 beat 0 data after precharge", int'(rd_valid), 1);
    @(negedge clk);
    check("R11 beat 1 data after precharge", int'(rd_valid), 1);
    @(negedge clk);
    check("R11 no further read data", int'(rd_valid), 0);
    repeat (3) @(negedge clk);

    // R12 new write during a read restarts at its own column
    mrs(2, 0, 2, 0, 0, 0, "R2 four beats");
    @(negedge clk); cmd = C_RD; addr = 12'd1;
    @(negedge clk); cmd = C_NOP; addr = '0;
    check("R12 first read beat", int'(col), 1);
    @(negedge clk); cmd = C_WR; addr = 12'd9;
    check("R12 second read beat", int'(col), 2);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk); cmd = C_NOP; addr = '0;
      check("R12 restarted column", int'(col), 8 + ((1 + j) & 3));
      check("R12 restarted write enable", int'(wr_en), 1);
    end
    @(negedge clk);
    check("R12 restarted burst length", int'(col_valid), 0);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule